// File: doc/BRIEF.md
# Parallel Port Write Receiver

This block accepts bytes that a host pushes over a printer-style parallel cable and queues them for logic inside the chip. The host places a byte on an 8-bit bus and pulls an active-low strobe. Both arrive with no timing relation to the system clock. The block answers on a busy line. Transfers run one way only: the device never drives data back toward the host.

The strobe passes through a synchroniser and then a run-length filter. A change of the strobe level counts only after the new level has been seen on a set number of consecutive clocks. The data bus passes through a synchroniser of the same depth, so both arrive together. On a qualified falling strobe the block copies the synchronised byte into a hold register and raises busy. It then moves the byte into a 16-entry FIFO as soon as the FIFO has a free slot. Busy drops only once the byte is in the FIFO and the filtered strobe has gone high again. A full FIFO therefore throttles the host, and no byte is lost. Downstream logic drains the FIFO through a valid/ready pair.

Top module: `pport_write_rx`

## Requirements
- R1: The synchronous active-high reset empties the FIFO and clears busy. After reset `hostBusy` and `outValid` are both 0.
- R2: A low pulse on `hostStrobeN` that lasts fewer than FILTER_LEN (default 4) clock cycles produces no busy and no byte.
- R3: A strobe that is held low is qualified after SYNC_STAGES + FILTER_LEN clock edges. With the defaults, `hostBusy` reads 0 after the fifth rising edge that follows the fall and 1 after the sixth. The byte captured is the value on `hostData` while the strobe was low.
- R4: If the FIFO has room, the captured byte appears at the FIFO output one edge after busy rises (after the seventh edge with the defaults).
- R5: Busy is released SYNC_STAGES + FILTER_LEN + 1 edges after the strobe returns high, and only once the byte has been written into the FIFO. With the defaults, busy still reads 1 after six edges and reads 0 after seven.
- R6: Bytes leave the FIFO in the order they were received. The FIFO holds FIFO_DEPTH (default 16) bytes.
- R7: While the FIFO is full, a byte that has been captured stays in the hold register and busy stays 1, even after the strobe has returned high. The byte is written, and busy released, once an entry is popped. No byte is dropped.
- R8: An entry is removed only on a cycle with `outValid` and `outReady` both 1. While `outValid` is 1 and `outReady` is 0, `outData` holds its value.
- R9: Changes on `hostData` after busy has risen have no effect on the byte already captured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hostData | input | 8 | Byte from the host, asynchronous |
| hostStrobeN | input | 1 | Active-low byte strobe from the host, asynchronous |
| hostBusy | output | 1 | Busy answer to the host |
| outData | output | 8 | Byte at the head of the FIFO |
| outValid | output | 1 | FIFO holds at least one byte |
| outReady | input | 1 | Downstream accepts the head byte |

## Verification
Each result of this block falls due at a fixed number of clock edges after its stimulus. Busy rises six edges after the strobe falls, and the byte is valid at the output one edge later. Busy falls seven edges after the strobe rises. A pop shows up at the output one edge after the ready cycle. The bench changes inputs only on falling clock edges. It then counts falling edges and samples both the last cycle before each result is due and the cycle in which it is due, so the checks catch a result that is one edge early or one edge late. The checks against the table of vectors allow a wide margin, since those checks concern which byte arrives, not when it arrives.

// File: rtl/pport_rx_pkg.sv
package pport_rx_pkg;
  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_PEND = 2'd1,
    RX_DONE = 2'd2
  } rxState_t;

  typedef struct packed {
    logic capture;
    logic push;
  } rxCmd_t;
endpackage

// File: rtl/pport_rx_ctrl.sv
module pport_rx_ctrl
  import pport_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILTER_LEN  = 4
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   hostStrobeN,
  input  logic   fifoFull,
  output rxCmd_t cmd,
  output logic   busy
);
  localparam int CNT_W = (FILTER_LEN > 1) ? $clog2(FILTER_LEN) : 1;
  localparam logic [CNT_W-1:0] RUN_LAST = CNT_W'(FILTER_LEN - 1);

  logic [SYNC_STAGES-1:0] strobeShift;
  logic                   strobeSync;
  logic                   fltLevel;
  logic [CNT_W-1:0]       runCnt;
  logic                   mismatch;
  logic                   flip;
  logic                   fallEvent;
  rxState_t               state, stateNext;

  always_ff @(posedge clk) begin
    if (rst) strobeShift <= '1;
    else     strobeShift <= {strobeShift[SYNC_STAGES-2:0], hostStrobeN};
  end
  assign strobeSync = strobeShift[SYNC_STAGES-1];

  // Level filter: the filtered strobe follows only after a full run of equal samples.
  assign mismatch  = (strobeSync != fltLevel);
  assign flip      = mismatch && (runCnt == RUN_LAST);
  assign fallEvent = flip && fltLevel;

  always_ff @(posedge clk) begin
    if (rst) begin
      fltLevel <= 1'b1;
      runCnt   <= '0;
    end else if (!mismatch) begin
      runCnt   <= '0;
    end else if (flip) begin
      fltLevel <= ~fltLevel;
      runCnt   <= '0;
    end else begin
      runCnt   <= runCnt + 1'b1;
    end
  end

  always_comb begin
    stateNext   = state;
    cmd.capture = 1'b0;
    cmd.push    = 1'b0;
    unique case (state)
      RX_IDLE: if (fallEvent) begin
        cmd.capture = 1'b1;
        stateNext   = RX_PEND;
      end
      RX_PEND: if (!fifoFull) begin
        cmd.push  = 1'b1;
        stateNext = RX_DONE;
      end
      RX_DONE: if (fltLevel) stateNext = RX_IDLE;
      default: stateNext = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= RX_IDLE;
    else     state <= stateNext;
  end

  assign busy = (state != RX_IDLE);

  // A capture is only ever taken while the synchronised strobe is low.
  assert_capture_filtered_R2: assert property (@(posedge clk) disable iff (rst)
    cmd.capture |-> !strobeSync);

  // Busy is raised on the edge that captures the byte.
  assert_busy_after_capture_R3: assert property (@(posedge clk) disable iff (rst)
    cmd.capture |=> busy);

  // Busy is never released while the synchronised strobe is still low.
  assert_release_strobe_high_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(strobeSync));
endmodule

// File: rtl/pport_rx_datapath.sv
module pport_rx_datapath
  import pport_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int FIFO_DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] hostData,
  input  rxCmd_t            cmd,
  output logic              fifoFull,
  output logic [DATA_W-1:0] outData,
  output logic              outValid,
  input  logic              outReady
);
  localparam int PTR_W = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(FIFO_DEPTH - 1);

  logic [SYNC_STAGES-1:0][DATA_W-1:0] dataShift;
  logic [DATA_W-1:0] holdByte;
  logic [DATA_W-1:0] mem [FIFO_DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  fifoCount;
  logic              doPop;

  always_ff @(posedge clk) begin
    if (rst) dataShift <= '0;
    else     dataShift <= {dataShift[SYNC_STAGES-2:0], hostData};
  end

  always_ff @(posedge clk) begin
    if (rst)              holdByte <= '0;
    else if (cmd.capture) holdByte <= dataShift[SYNC_STAGES-1];
  end

  assign doPop    = outValid && outReady;
  assign outValid = (fifoCount != '0);
  assign fifoFull = (fifoCount == CNT_W'(FIFO_DEPTH));
  assign outData  = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (cmd.push) mem[wrPtr] <= holdByte;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fifoCount <= '0;
    end else begin
      if (cmd.push) wrPtr <= (wrPtr == PTR_LAST) ? '0 : wrPtr + 1'b1;
      if (doPop)    rdPtr <= (rdPtr == PTR_LAST) ? '0 : rdPtr + 1'b1;
      case ({cmd.push, doPop})
        2'b10:   fifoCount <= fifoCount + 1'b1;
        2'b01:   fifoCount <= fifoCount - 1'b1;
        default: fifoCount <= fifoCount;
      endcase
    end
  end

  // The controller never writes into a full FIFO.
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    cmd.push |-> !fifoFull);

  // A head that is not taken stays put.
  assert_head_stable_R8: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady && !cmd.push) |=> (outValid && $stable(outData)));

  // The captured byte is held until it has been written.
  assert_hold_stable_R9: assert property (@(posedge clk) disable iff (rst)
    (!cmd.capture && !$past(cmd.capture)) |-> $stable(holdByte));
endmodule

// File: rtl/pport_write_rx.sv
module pport_write_rx
  import pport_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int FILTER_LEN  = 4,
  parameter int FIFO_DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] hostData,
  input  logic              hostStrobeN,
  output logic              hostBusy,
  output logic [DATA_W-1:0] outData,
  output logic              outValid,
  input  logic              outReady
);
  rxCmd_t cmd;
  logic   fifoFull;

  pport_rx_ctrl #(
    .SYNC_STAGES(SYNC_STAGES),
    .FILTER_LEN (FILTER_LEN)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .hostStrobeN(hostStrobeN),
    .fifoFull   (fifoFull),
    .cmd        (cmd),
    .busy       (hostBusy)
  );

  pport_rx_datapath #(
    .DATA_W     (DATA_W),
    .SYNC_STAGES(SYNC_STAGES),
    .FIFO_DEPTH (FIFO_DEPTH)
  ) u_datapath (
    .clk     (clk),
    .rst     (rst),
    .hostData(hostData),
    .cmd     (cmd),
    .fifoFull(fifoFull),
    .outData (outData),
    .outValid(outValid),
    .outReady(outReady)
  );

  // Reset leaves the block idle and empty on the following cycle.
  assert_reset_idle_R1: assert property (@(posedge clk)
    $past(rst) |-> (!hostBusy && !outValid));
endmodule

// File: tb/pport_write_rx_bench.sv
module pport_write_rx_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] hostData = 8'h00;
  logic       hostStrobeN = 1'b1;
  logic       hostBusy;
  logic [7:0] outData;
  logic       outValid;
  logic       outReady = 1'b0;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 1'b0;

  always #4 clk = ~clk;

  pport_write_rx u_pport_write_rx (
    .clk(clk), .rst(rst), .hostData(hostData), .hostStrobeN(hostStrobeN),
    .hostBusy(hostBusy), .outData(outData), .outValid(outValid), .outReady(outReady)
  );

  // {data, low cycles, accepted}
  localparam logic [16:0] VEC [0:5] = '{
    {8'hA5, 8'd10, 1'b1},
    {8'h3C, 8'd2,  1'b0},
    {8'h00, 8'd4,  1'b1},
    {8'hFF, 8'd3,  1'b0},
    {8'h5A, 8'd20, 1'b1},
    {8'h81, 8'd5,  1'b1}
  };

  task automatic checkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitNeg(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hostWrite(input logic [7:0] b, input int lowCycles, input int highCycles);
    hostData    = b;
    hostStrobeN = 1'b0;
    waitNeg(lowCycles);
    hostStrobeN = 1'b1;
    waitNeg(highCycles);
  endtask

  task automatic popExpect(input string tag, input logic [7:0] exp);
    checkEq({tag, " valid"}, outValid, 1'b1);
    checkEq({tag, " data"}, outData, exp);
    outReady = 1'b1;
    waitNeg(1);
    outReady = 1'b0;
  endtask

  initial begin
    waitNeg(4);
    rst = 1'b0;
    waitNeg(1);
    checkEq("R1 busy after reset", hostBusy, 1'b0);
    checkEq("R1 valid after reset", outValid, 1'b0);

    // Table walk: glitch rejection and captured values (R2, R3, R4)
    for (int i = 0; i < 6; i++) begin
      hostWrite(VEC[i][16:9], int'(VEC[i][8:1]), 14);
      if (VEC[i][0]) begin
        popExpect("R4 table byte", VEC[i][16:9]);
      end else begin
        checkEq("R2 glitch no byte", outValid, 1'b0);
        checkEq("R2 glitch no busy", hostBusy, 1'b0);
      end
    end

    // Exact latencies (R3, R4, R5) and data change after capture (R9)
    hostData    = 8'hC3;
    hostStrobeN = 1'b0;
    waitNeg(5);
    checkEq("R3 busy not yet", hostBusy, 1'b0);
    waitNeg(1);
    checkEq("R3 busy rise", hostBusy, 1'b1);
    checkEq("R4 valid not yet", outValid, 1'b0);
    hostData = 8'h1E;
    waitNeg(1);
    checkEq("R4 valid rise", outValid, 1'b1);
    checkEq("R9 captured byte", outData, 8'hC3);
    waitNeg(3);
    hostStrobeN = 1'b1;
    waitNeg(6);
    checkEq("R5 busy still held", hostBusy, 1'b1);
    waitNeg(1);
    checkEq("R5 busy release", hostBusy, 1'b0);
    // R8: head holds while not ready
    waitNeg(3);
    checkEq("R8 head held", outData, 8'hC3);
    checkEq("R8 still valid", outValid, 1'b1);
    popExpect("R8 pop", 8'hC3);
    checkEq("R8 empty after pop", outValid, 1'b0);

    // Full FIFO: 16 accepted, 17th stalls busy (R6, R7)
    for (int i = 0; i < 16; i++) begin
      hostWrite(8'h40 + 8'(i), 10, 12);
      checkEq("R6 fill busy low", hostBusy, 1'b0);
    end
    hostWrite(8'h50, 10, 20);
    checkEq("R7 busy held when full", hostBusy, 1'b1);
    popExpect("R7 first pop", 8'h40);
    waitNeg(4);
    checkEq("R7 busy released", hostBusy, 1'b0);
    for (int i = 1; i < 17; i++) begin
      popExpect("R6 order", 8'h40 + 8'(i));
    end
    checkEq("R6 drained", outValid, 1'b0);

    // Reset mid-stream clears content and busy (R1)
    hostWrite(8'h77, 10, 12);
    hostData    = 8'h66;
    hostStrobeN = 1'b0;
    waitNeg(8);
    rst = 1'b1;
    waitNeg(2);
    hostStrobeN = 1'b1;
    rst = 1'b0;
    waitNeg(1);
    checkEq("R1 busy cleared", hostBusy, 1'b0);
    checkEq("R1 fifo emptied", outValid, 1'b0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule